// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external host reach a 64-entry byte register file over a four-signal serial link (serial clock, active-low select and one or two data pins). Every transfer opens with a 16-bit command: one operation bit and a 15-bit start address. Any number of data bytes follow. After each byte the address steps on by one, so a single select window can cover a run of registers. A control byte at address 0 sets three things: the bit order (most or least significant bit first), the direction in which the address steps, and whether read data goes out on the shared bidirectional data pin (3-wire) or on a separate output pin (4-wire).

The serial pins are oversampled by the system clock through synchronizers. Input bits are taken on serial-clock rising edges and output bits are launched on falling edges. A chip-side port exposes each accepted write as a one-cycle strobe with its address and byte. It also provides a read port onto the current register contents and a status byte input that the host can read. While a boot-disable input is high, the serial side is held idle and drives nothing.

Top module: `spi_reg_slave`

## Requirements
- R1: The command word is 16 bits. Its bit 15 is the operation (1 = read, 0 = write) and bits 14..0 are the start address. Data bytes follow it in the same select window.
- R2: Input bits are sampled on serial-clock rising edges. Read data changes only after falling edges, and the first data bit is driven after the falling edge that follows the last command bit. Neither output enable is high during the command.
- R3: Deasserting and reasserting select restarts the command phase, even part-way through a word. While select is high, both output enables are low.
- R4: Each written byte reaches its register (and raises `rf_we`) when that byte's eighth bit is sampled, before select goes high.
- R5: After reset the control byte is 0x00. Bits go most significant first and the address decrements after each data byte. With control bit 6 set, every word (command and data) goes least significant bit first and the address increments.
- R6: Control bit 5 set makes the address increment in most-significant-first mode too.
- R7: Control bit 4 at 0 sends read data on `sdio_out` with `sdio_oe` and keeps `sdo_oe` low. At 1 it sends read data on `sdo` with `sdo_oe` and keeps `sdio_oe` low.
- R8: A control write sets each of bits 7..4 when either that bit or its mirror (bit 7-k) is 1. The control byte reads back as {0, b6, b5, b4, b4, b5, b6, 0}.
- R9: A control write with bit 7 or bit 0 set clears the control byte and every register from 0x04 to 0x3F to 0x00.
- R10: While `boot_dis` is high, serial accesses write nothing and neither output enable rises.
- R11: Address 0x01 reads the revision (0x12 by default) and 0x02 reads `stat_in`. Address 0x03 reads the XOR of registers 0x04..0x3F. All three ignore writes. Addresses 0x0040 and above read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_dis | input | 1 | Holds the serial side idle while high |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Read data for the shared data pin |
| sdio_oe | output | 1 | Drive enable of the shared data pin |
| sdo | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Drive enable of the separate output pin |
| stat_in | input | 8 | Status byte readable at address 0x02 |
| core_raddr | input | 6 | Chip-side register read address |
| core_rdata | output | 8 | Chip-side register read data |
| rf_we | output | 1 | One-cycle strobe for each accepted write |
| rf_waddr | output | 6 | Register index of the accepted write |
| rf_wdata | output | 8 | Byte of the accepted write |

## Verification
The checker watches, on every cycle, a small set of rules. Both enables go low after select is high. Boot-disable suppresses writes and drive. Read data moves only after a synchronized falling edge. Write strobes follow a rising edge and never name a read-only register. The bench scenarios are the only place where the following can be seen: the command layout, both bit orders, each step direction, control mirroring, soft reset, read-back of read-only and unmapped addresses, and recovery from a select aborted part-way through a word. The bench compares serial reads and chip-side strobes against its own register model.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W    = 8;
  localparam int CTRL_ADDR = 0;
  localparam int REV_ADDR  = 1;
  localparam int STAT_ADDR = 2;
  localparam int CSUM_ADDR = 3;
  localparam int FIRST_GEN = 4;
  localparam int CB_RST    = 7;
  localparam int CB_LSB    = 6;
  localparam int CB_INC    = 5;
  localparam int CB_SDO    = 4;

  typedef struct packed {
    logic lsb_first;
    logic addr_up;
    logic sdo_mode;
  } cfg_t;

  typedef enum logic [1:0] {PH_INSTR, PH_WDATA, PH_RDATA} phase_t;

  function automatic logic [BYTE_W-1:0] mirror8(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL[g]}};
      else        pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign q[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/spi_serial_fsm.sv
module spi_serial_fsm
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cs_q,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din_q,
  input  cfg_t              cfg,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              dout,
  output logic              drive
);
  localparam int INSTR_W = ADDR_W + 1;
  localparam int ICNT_W  = $clog2(INSTR_W);
  localparam int BCNT_W  = $clog2(BYTE_W);

  phase_t             ph;
  logic [ICNT_W-1:0]  icnt;
  logic [INSTR_W-1:0] isr;
  logic [BCNT_W-1:0]  dcnt;
  logic [BYTE_W-1:0]  dsr;
  logic [BYTE_W-1:0]  txb;

  logic               step_up;
  logic [ADDR_W-1:0]  next_addr;
  logic [INSTR_W-1:0] isr_nx;
  logic [BYTE_W-1:0]  dsr_nx;
  logic [BCNT_W-1:0]  tx_idx;
  logic               last_bit;
  logic               last_cmd;

  always_comb begin
    step_up   = cfg.lsb_first | cfg.addr_up;
    next_addr = step_up ? acc_addr + 1'b1 : acc_addr - 1'b1;
    isr_nx    = cfg.lsb_first ? {din_q, isr[INSTR_W-1:1]} : {isr[INSTR_W-2:0], din_q};
    dsr_nx    = cfg.lsb_first ? {din_q, dsr[BYTE_W-1:1]}  : {dsr[BYTE_W-2:0], din_q};
    tx_idx    = cfg.lsb_first ? dcnt : BCNT_W'(BYTE_W-1) - dcnt;
    last_bit  = (dcnt == BCNT_W'(BYTE_W-1));
    last_cmd  = (icnt == ICNT_W'(INSTR_W-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_INSTR;
      icnt     <= '0;
      isr      <= '0;
      dcnt     <= '0;
      dsr      <= '0;
      txb      <= '0;
      acc_addr <= '0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_byte  <= '0;
      dout     <= 1'b0;
      drive    <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (!en || cs_q) begin
        ph    <= PH_INSTR;
        icnt  <= '0;
        dcnt  <= '0;
        drive <= 1'b0;
      end else begin
        if (sclk_rise) begin
          unique case (ph)
            PH_INSTR: begin
              isr <= isr_nx;
              if (last_cmd) begin
                ph       <= isr_nx[INSTR_W-1] ? PH_RDATA : PH_WDATA;
                acc_addr <= isr_nx[ADDR_W-1:0];
                icnt     <= '0;
                dcnt     <= '0;
              end else begin
                icnt <= icnt + 1'b1;
              end
            end
            PH_WDATA: begin
              dsr  <= dsr_nx;
              dcnt <= dcnt + 1'b1;
              if (last_bit) begin
                wr_stb   <= 1'b1;
                wr_byte  <= dsr_nx;
                wr_addr  <= acc_addr;
                acc_addr <= next_addr;
              end
            end
            PH_RDATA: begin
              dcnt <= dcnt + 1'b1;
              if (last_bit) acc_addr <= next_addr;
            end
            default: ph <= PH_INSTR;
          endcase
        end
        if (sclk_fall && ph == PH_RDATA) begin
          drive <= 1'b1;
          if (dcnt == '0) begin
            txb  <= rd_byte;
            dout <= rd_byte[tx_idx];
          end else begin
            dout <= txb[tx_idx];
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int REG_AW = 6,
  parameter logic [BYTE_W-1:0] REV_ID = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_AW-1:0] core_raddr,
  input  logic [BYTE_W-1:0] stat_in,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] core_rdata,
  output cfg_t              cfg,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [BYTE_W-1:0] rf_wdata
);
  localparam int NREGS = 1 << REG_AW;

  logic [BYTE_W-1:0] mem [NREGS];
  logic [BYTE_W-1:0] csum;
  logic [REG_AW-1:0] wa;
  logic              wr_in_map;
  logic              wr_ro;
  logic              wr_ok;
  logic              wr_ctrl;
  logic [BYTE_W-1:0] ctrl_set;
  logic              soft_rst;

  always_comb begin
    wa        = wr_addr[REG_AW-1:0];
    wr_in_map = (wr_addr[ADDR_W-1:REG_AW] == '0);
    wr_ro     = (wa == REG_AW'(REV_ADDR)) || (wa == REG_AW'(STAT_ADDR)) ||
                (wa == REG_AW'(CSUM_ADDR));
    wr_ok     = wr_stb && wr_in_map && !wr_ro;
    wr_ctrl   = wr_ok && (wa == REG_AW'(CTRL_ADDR));
    ctrl_set  = wr_byte | mirror8(wr_byte);
    soft_rst  = wr_ctrl && ctrl_set[CB_RST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (soft_rst) begin
      cfg <= '0;
    end else if (wr_ctrl) begin
      cfg.lsb_first <= ctrl_set[CB_LSB];
      cfg.addr_up   <= ctrl_set[CB_INC];
      cfg.sdo_mode  <= ctrl_set[CB_SDO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_ok && wa >= REG_AW'(FIRST_GEN)) begin
      mem[wa] <= wr_byte;
    end
  end

  always_comb begin
    csum = '0;
    for (int i = FIRST_GEN; i < NREGS; i++) csum = csum ^ mem[i];
  end

  function automatic logic [BYTE_W-1:0] view_of(input logic [REG_AW-1:0] a);
    logic [BYTE_W-1:0] v;
    if (a == REG_AW'(CTRL_ADDR))
      v = {1'b0, cfg.lsb_first, cfg.addr_up, cfg.sdo_mode,
           cfg.sdo_mode, cfg.addr_up, cfg.lsb_first, 1'b0};
    else if (a == REG_AW'(REV_ADDR))  v = REV_ID;
    else if (a == REG_AW'(STAT_ADDR)) v = stat_in;
    else if (a == REG_AW'(CSUM_ADDR)) v = csum;
    else                              v = mem[a];
    return v;
  endfunction

  always_comb begin
    rd_byte    = (acc_addr[ADDR_W-1:REG_AW] == '0) ? view_of(acc_addr[REG_AW-1:0]) : '0;
    core_rdata = view_of(core_raddr);
    rf_we      = wr_ok;
    rf_waddr   = wa;
    rf_wdata   = wr_byte;
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int REG_AW      = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] REV_ID = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_dis,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [7:0]        stat_in,
  input  logic [REG_AW-1:0] core_raddr,
  output logic [7:0]        core_rdata,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [7:0]        rf_wdata
);
  localparam int NPINS = 3;

  logic [NPINS-1:0]  pin_q;
  logic              sclk_q, cs_q, din_q, sclk_d;
  logic              sclk_rise, sclk_fall;
  cfg_t              cfg;
  logic [ADDR_W-1:0] acc_addr, wr_addr;
  logic [7:0]        rd_byte, wr_byte;
  logic              wr_stb, dout, drive;

  spi_pin_sync #(.N(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdio_in, cs_n, sclk}), .q(pin_q)
  );

  assign sclk_q = pin_q[0];
  assign cs_q   = pin_q[1];
  assign din_q  = pin_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_q;
  end

  assign sclk_rise = sclk_q & ~sclk_d;
  assign sclk_fall = ~sclk_q & sclk_d;

  spi_serial_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(!boot_dis), .cs_q(cs_q),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din_q(din_q),
    .cfg(cfg), .rd_byte(rd_byte), .acc_addr(acc_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .dout(dout), .drive(drive)
  );

  spi_reg_bank #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .REV_ID(REV_ID)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_byte(wr_byte), .acc_addr(acc_addr), .core_raddr(core_raddr),
    .stat_in(stat_in), .rd_byte(rd_byte), .core_rdata(core_rdata),
    .cfg(cfg), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  assign sdio_out = dout;
  assign sdo      = dout;
  assign sdio_oe  = drive & ~cfg.sdo_mode;
  assign sdo_oe   = drive & cfg.sdo_mode;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int REG_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boot_dis,
  input logic              cs_q,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              sdio_out,
  input logic              sdio_oe,
  input logic              sdo_oe,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_waddr
);
  // R3: select high leaves both pins undriven on the next cycle
  assert_cs_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> (!sdio_oe && !sdo_oe));

  // R10: boot-disable blocks writes and drive
  assert_boot_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    boot_dis |=> (!rf_we && !sdio_oe && !sdo_oe));

  // R2: read data only moves after a synchronized falling edge
  assert_launch_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdio_out) |-> $past(sclk_fall));

  // R4: a write strobe follows the rising edge that completed the byte
  assert_write_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(sclk_rise));

  // R11: read-only registers never receive a write strobe
  assert_ro_protected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != REG_AW'(1) && rf_waddr != REG_AW'(2) && rf_waddr != REG_AW'(3)));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .boot_dis(boot_dis), .cs_q(cs_q),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdio_out(sdio_out),
  .sdio_oe(sdio_oe), .sdo_oe(sdo_oe), .rf_we(rf_we), .rf_waddr(rf_waddr)
);

// File: tb/tb_spi_reg_slave.sv
`timescale 1ns/1ps
module tb_spi_reg_slave;
  localparam int HALF = 8;
  localparam logic [7:0] REV = 8'h12;
  localparam logic [7:0] STAT = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_dis = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo, sdo_oe, rf_we;
  logic [7:0] stat_in = STAT;
  logic [5:0] core_raddr = '0, rf_waddr;
  logic [7:0] core_rdata, rf_wdata;

  always #10 clk = ~clk;

  spi_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .boot_dis(boot_dis), .sclk(sclk), .cs_n(cs_n),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
    .sdo_oe(sdo_oe), .stat_in(stat_in), .core_raddr(core_raddr),
    .core_rdata(core_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0, oe_bad = 0;
  logic [7:0] m_mem [64];
  bit m_lsb = 0, m_inc = 0, m_sdo = 0;
  logic [13:0] exp_wr_q [$];
  logic [7:0] exp_rd_q [$];
  logic [7:0] tx_bytes [8];

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] m_view(input logic [14:0] a);
    logic [7:0] c;
    if (a[14:6] != 0) return 8'h00;
    case (a[5:0])
      6'd0: return {1'b0, m_lsb, m_inc, m_sdo, m_sdo, m_inc, m_lsb, 1'b0};
      6'd1: return REV;
      6'd2: return STAT;
      6'd3: begin
        c = 0;
        for (int i = 4; i < 64; i++) c ^= m_mem[i];
        return c;
      end
      default: return m_mem[a[5:0]];
    endcase
  endfunction

  function automatic logic [14:0] m_step(input logic [14:0] a);
    return (m_lsb || m_inc) ? a + 15'd1 : a - 15'd1;
  endfunction

  task automatic m_write(input logic [14:0] a, input logic [7:0] d);
    logic [7:0] s;
    if (a[14:6] != 0 || a[5:0] inside {6'd1, 6'd2, 6'd3}) return;
    exp_wr_q.push_back({a[5:0], d});
    if (a[5:0] == 0) begin
      for (int i = 0; i < 8; i++) s[i] = d[i] | d[7-i];
      if (s[7]) begin
        m_lsb = 0; m_inc = 0; m_sdo = 0;
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
      end else begin
        m_lsb = s[6]; m_inc = s[5]; m_sdo = s[4];
      end
    end else m_mem[a[5:0]] = d;
  endtask

  // write-port monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      if (exp_wr_q.size() == 0) chk(0, "R11 unexpected write", int'({rf_waddr, rf_wdata}), 0);
      else begin
        logic [13:0] e;
        e = exp_wr_q.pop_front();
        chk({rf_waddr, rf_wdata} == e, "R4 write strobe", int'({rf_waddr, rf_wdata}), int'(e));
      end
    end
    if (boot_dis && (sdio_oe || sdo_oe)) oe_bad = 1;
  end

  task automatic bit_x(input logic b, output logic got, output int pin);
    @(negedge clk);
    sclk = 0; sdio_in = b;
    repeat (HALF) @(negedge clk);
    got = sdo_oe ? sdo : sdio_out;
    pin = sdo_oe ? 2 : (sdio_oe ? 1 : 0);
    sclk = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_txn();
    @(negedge clk); sclk = 0;
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic txn(input bit rd, input logic [14:0] addr, input int n,
                     input bit model, input string tag);
    logic [15:0] w;
    logic [14:0] a, na;
    logic [7:0] b, gb;
    logic got;
    int pin, first_pin;
    bit lsb, cmd_quiet;
    lsb = m_lsb; w = {rd, addr}; a = addr; cmd_quiet = 1;
    @(negedge clk); cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      bit_x(lsb ? w[i] : w[15-i], got, pin);
      if (pin != 0) cmd_quiet = 0;
    end
    if (model) chk(cmd_quiet, "R2 no drive during command", 0, 1);
    for (int k = 0; k < n; k++) begin
      b = rd ? 8'h00 : tx_bytes[k];
      na = m_step(a);
      if (model && rd) exp_rd_q.push_back(m_view(a));
      if (model && !rd) m_write(a, b);
      first_pin = 0;
      for (int j = 0; j < 8; j++) begin
        bit_x(lsb ? b[j] : b[7-j], got, pin);
        gb[lsb ? j : 7-j] = got;
        if (j == 0) first_pin = pin;
      end
      if (model && rd) begin
        logic [7:0] e;
        e = exp_rd_q.pop_front();
        chk(gb === e, {tag, " read data"}, int'(gb), int'(e));
        chk(first_pin == (m_sdo ? 2 : 1), "R7 data pin", first_pin, m_sdo ? 2 : 1);
      end
      if (model && !rd && a[14:6] == 0) begin
        core_raddr = a[5:0];
        @(negedge clk);
        chk(core_rdata == m_view(a), "R4 update before select release", int'(core_rdata), int'(m_view(a)));
      end
      a = na;
    end
    end_txn();
  endtask

  task automatic wr1(input logic [14:0] a, input logic [7:0] d, input string tag);
    tx_bytes[0] = d;
    txn(0, a, 1, 1, tag);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R3 / R5 / R11 reset state
    chk(!sdio_oe && !sdo_oe, "R3 reset enables", {sdio_oe, sdo_oe}, 0);
    core_raddr = 0; @(negedge clk);
    chk(core_rdata == 8'h00, "R5 reset control", int'(core_rdata), 0);
    core_raddr = 1; @(negedge clk);
    chk(core_rdata == REV, "R11 revision", int'(core_rdata), int'(REV));

    // R1 single write and read back, MSB first
    wr1(15'h0010, 8'h3C, "R1");
    txn(1, 15'h0010, 1, 1, "R1");

    // R10 boot disable: access ignored
    boot_dis = 1;
    tx_bytes[0] = 8'h77;
    txn(0, 15'h0010, 1, 0, "R10");
    txn(1, 15'h0010, 1, 0, "R10");
    chk(!oe_bad, "R10 no drive", oe_bad, 0);
    boot_dis = 0;
    txn(1, 15'h0010, 1, 1, "R10");

    // R5 decrementing burst write and read
    tx_bytes[0] = 8'hA1; tx_bytes[1] = 8'hB2; tx_bytes[2] = 8'hC3;
    txn(0, 15'h0022, 3, 1, "R5");
    txn(1, 15'h0022, 3, 1, "R5");

    // R3 aborted command, then a clean read
    begin
      logic g; int p;
      @(negedge clk); cs_n = 0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < 7; i++) bit_x(1'b1, g, p);
      end_txn();
      chk(!sdio_oe && !sdo_oe, "R3 released", {sdio_oe, sdo_oe}, 0);
    end
    txn(1, 15'h0010, 1, 1, "R3");

    // R6 increment in MSB mode, R8 mirror read-back
    wr1(15'h0000, 8'h20, "R6");
    txn(1, 15'h0000, 1, 1, "R8");
    tx_bytes[0] = 8'h5E; tx_bytes[1] = 8'h6F;
    txn(0, 15'h0030, 2, 1, "R6");
    txn(1, 15'h0030, 2, 1, "R6");

    // R8 mirror bit enables LSB first, R5 LSB incrementing
    wr1(15'h0000, 8'h02, "R8");
    txn(1, 15'h0000, 1, 1, "R8");
    txn(1, 15'h0022, 2, 1, "R5");
    tx_bytes[0] = 8'h81; tx_bytes[1] = 8'h18;
    txn(0, 15'h0008, 2, 1, "R5");
    txn(1, 15'h0008, 2, 1, "R5");

    // R7 four-wire mode
    wr1(15'h0000, 8'h50, "R7");
    txn(1, 15'h0000, 1, 1, "R7");
    txn(1, 15'h0030, 2, 1, "R7");

    // R11 read-only and unmapped addresses
    wr1(15'h0001, 8'hFF, "R11");
    wr1(15'h0002, 8'hFF, "R11");
    wr1(15'h0003, 8'hFF, "R11");
    wr1(15'h0100, 8'hEE, "R11");
    txn(1, 15'h0001, 3, 1, "R11");
    txn(1, 15'h0100, 1, 1, "R11");

    // R9 soft reset via bit 7 (sent LSB first)
    wr1(15'h0000, 8'h80, "R9");
    txn(1, 15'h0000, 1, 1, "R9");
    txn(1, 15'h0030, 1, 1, "R9");
    core_raddr = 6'h22; @(negedge clk);
    chk(core_rdata == 8'h00, "R9 cleared", int'(core_rdata), 0);

    repeat (10) @(negedge clk);
    chk(exp_wr_q.size() == 0, "R4 missing writes", exp_wr_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule